// File: doc/BRIEF.md
# Half-Duplex Serial Flash Master

This block connects a processor's simple 32-bit register bus to a serial NOR boot flash. Software controls the two active-low chip-select pins directly through register bits. It sets a transfer length of one to four bytes. Each access to the data register then moves that many bytes across the serial link. A write to the data register sends bytes on MOSI only. A read of the data register receives bytes from MISO only. The bus read is held off until the last received bit has arrived.

The serial clock follows SPI mode 0. It idles low, the flash samples on the rising edge and the data line changes on the falling edge. Each half period lasts a fixed number of system clocks, set by a parameter. Bits within a byte always move most significant first. Two configuration bits choose the byte order separately for transmit and for receive. A ready flag in the status register shows when the engine is idle.

The bytes of an access occupy the upper end of the 32-bit word. An access of L bytes uses bits 31 down to 32-8L. A single byte therefore always sits in bits 31:24.

Top module: `spi_flash_master`

## Requirements
- R1: After reset, both chip-select pins are high. The length code is 0, the ready flag is 1 and both byte-order bits are 0. The status word therefore reads 0xC800_0000 and the configuration word reads 0.
- R2: Registers are decoded at byte offsets 0x0 (configuration), 0x8 (status/control) and 0xC (data). In the configuration register only bit 28 (receive order) and bit 27 (transmit order) are stored. In the status register bits 31:28 are stored and bit 27 is read-only. Every other bit reads as 0.
- R3: Chip-select pin 0 (csN[0]) follows status bit 31 and chip-select pin 1 (csN[1]) follows status bit 30, one cycle after the write. A pin is low when its bit is 0.
- R4: The length code in status bits 29:28 selects a transfer of code+1 bytes. Such a transfer produces exactly 8*(code+1) rising serial clock edges.
- R5: The serial clock is low whenever no transfer runs. During a transfer each half period lasts CLK_DIV system clocks, starting with a low half. MOSI changes only on a falling edge. MISO is sampled at each rising edge.
- R6: A data write sends only the bytes of the top-aligned field, each byte most significant bit first. MOSI is 0 when no transmit runs.
- R7: When configuration bit 27 is 1, a transmit sends the highest byte of the field first. When it is 0, the transmit sends the lowest byte of the field first.
- R8: A data read issued while the engine is ready starts a receive with MOSI held at 0. busAck stays low until the cycle in which the transfer has ended. That cycle comes 2*CLK_DIV*8*(code+1) cycles after the request is accepted. The returned word holds the received bytes in the top-aligned field, with all lower bits 0.
- R9: When configuration bit 28 is 1, the first received byte is placed in the highest byte of the field. When it is 0, the first received byte is placed in the lowest byte of the field.
- R10: The ready flag reads 0 from the cycle after an accepted data access until the transfer ends. A data write that arrives while ready is 0 is acknowledged but has no effect on the pins.
- R11: Every access other than a data read is acknowledged in the same cycle its request is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Bus request, held until busAck |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 4 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while busAck is high |
| busAck | output | 1 | Request completes in this cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| csN | output | 2 | Active-low chip selects |

## Verification
The assertions check the following on every cycle:
- the serial clock and MOSI are quiet outside a transfer;
- MOSI changes only at a falling clock edge;
- the chip selects move only after a status write;
- ready drops right after an accepted access;
- MOSI stays low during a receive;
- every access other than a data read is acknowledged at once.

Some properties depend on data and can only be shown by the bench's scenarios: the byte order chosen by each configuration bit, the top-aligned placement for every length, the exact number of clock pulses, and the cycle in which a stalled read returns its word. The bench compares the pins against a cycle-counting reference on every clock to check these.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;

  localparam logic [3:0] ADDR_CFG  = 4'h0;
  localparam logic [3:0] ADDR_CSR  = 4'h8;
  localparam logic [3:0] ADDR_DATA = 4'hC;

  // strobes from control to datapath
  typedef struct packed {
    logic       start;
    logic       isRx;
    logic [1:0] lenCode;
    logic       msbFirst;
  } xferCmd_t;

  // Keep the top-aligned field of lenCode+1 bytes; in lsb-first order the
  // bytes of that field are reversed. Applying it twice gives the input.
  function automatic logic [31:0] orderBytes(input logic [31:0] w,
                                             input logic [1:0] lenCode,
                                             input logic msbFirst);
    logic [31:0] res;
    int src;
    res = '0;
    for (int i = 0; i < 4; i++) begin
      if (i <= int'(lenCode)) begin
        src = msbFirst ? i : int'(lenCode) - i;
        res[31 - 8*i -: 8] = w[31 - 8*src -: 8];
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/spi_flash_shifter.sv
module spi_flash_shifter
  import spi_flash_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  xferCmd_t    cmd,
  input  logic [31:0] txWord,
  input  logic        miso,
  output logic        active,
  output logic        sclk,
  output logic        mosi,
  output logic [31:0] rxWord
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] HALF_LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] halfCnt;
  logic [5:0]    bitsLeft;
  logic [31:0]   txShift;
  logic [31:0]   rxShift;
  logic [1:0]    lenL;
  logic          msbL;
  logic [4:0]    alignAmt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      sclk     <= 1'b0;
      halfCnt  <= '0;
      bitsLeft <= '0;
      txShift  <= '0;
      rxShift  <= '0;
      lenL     <= '0;
      msbL     <= 1'b0;
    end else if (cmd.start) begin
      active   <= 1'b1;
      sclk     <= 1'b0;
      halfCnt  <= '0;
      bitsLeft <= 6'({cmd.lenCode, 3'b000}) + 6'd8;
      txShift  <= cmd.isRx ? '0 : orderBytes(txWord, cmd.lenCode, cmd.msbFirst);
      rxShift  <= '0;
      lenL     <= cmd.lenCode;
      msbL     <= cmd.msbFirst;
    end else if (active) begin
      if (halfCnt == HALF_LAST) begin
        halfCnt <= '0;
        if (!sclk) begin
          sclk    <= 1'b1;
          rxShift <= {rxShift[30:0], miso};
        end else begin
          sclk     <= 1'b0;
          txShift  <= {txShift[30:0], 1'b0};
          bitsLeft <= bitsLeft - 6'd1;
          if (bitsLeft == 6'd1) active <= 1'b0;
        end
      end else begin
        halfCnt <= halfCnt + CW'(1);
      end
    end
  end

  assign mosi     = txShift[31];
  assign alignAmt = {2'd3 - lenL, 3'b000};
  assign rxWord   = orderBytes(rxShift << alignAmt, lenL, msbL);

endmodule

// File: rtl/spi_flash_regs.sv
module spi_flash_regs
  import spi_flash_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busValid,
  input  logic        busWrite,
  input  logic [3:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        busAck,
  input  logic        active,
  input  logic [31:0] rxWord,
  output xferCmd_t    cmd,
  output logic [31:0] txWord,
  output logic [1:0]  csN,
  output logic        rxPend
);
  logic       rdMsb, wrMsb;
  logic       csBit0, csBit1;
  logic [1:0] lenR;
  logic       isData, canStart, rxDone;

  assign isData   = (busAddr == ADDR_DATA);
  assign canStart = !active && !rxPend;
  assign rxDone   = rxPend && !active;

  assign cmd.start    = busValid && isData && canStart;
  assign cmd.isRx     = !busWrite;
  assign cmd.lenCode  = lenR;
  assign cmd.msbFirst = busWrite ? wrMsb : rdMsb;
  assign txWord       = busWdata;

  assign busAck = busValid && (!isData || busWrite || rxDone);

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_CFG:  busRdata = {3'b000, rdMsb, wrMsb, 27'd0};
      ADDR_CSR:  busRdata = {csBit0, csBit1, lenR, !active, 27'd0};
      ADDR_DATA: busRdata = rxWord;
      default:   busRdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdMsb  <= 1'b0;
      wrMsb  <= 1'b0;
      csBit0 <= 1'b1;
      csBit1 <= 1'b1;
      lenR   <= 2'd0;
      rxPend <= 1'b0;
    end else begin
      if (busValid && busWrite && busAddr == ADDR_CFG) begin
        rdMsb <= busWdata[28];
        wrMsb <= busWdata[27];
      end
      if (busValid && busWrite && busAddr == ADDR_CSR) begin
        csBit0 <= busWdata[31];
        csBit1 <= busWdata[30];
        lenR   <= busWdata[29:28];
      end
      if (cmd.start && !busWrite) rxPend <= 1'b1;
      else if (busValid && isData && !busWrite && rxDone) rxPend <= 1'b0;
    end
  end

  assign csN = {csBit1, csBit0};

endmodule

// File: rtl/spi_flash_master.sv
module spi_flash_master
  import spi_flash_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busValid,
  input  logic        busWrite,
  input  logic [3:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        busAck,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [1:0]  csN
);
  xferCmd_t    cmd;
  logic [31:0] txWord;
  logic [31:0] rxWord;
  logic        xferActive;
  logic        rxPend;

  spi_flash_regs u_regs (
    .clk(clk), .rstN(rstN),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck),
    .active(xferActive), .rxWord(rxWord),
    .cmd(cmd), .txWord(txWord), .csN(csN), .rxPend(rxPend)
  );

  spi_flash_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rstN(rstN), .cmd(cmd), .txWord(txWord), .miso(miso),
    .active(xferActive), .sclk(sclk), .mosi(mosi), .rxWord(rxWord)
  );

endmodule

// File: rtl/spi_flash_master_chk.sv
module spi_flash_master_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busValid,
  input logic       busWrite,
  input logic [3:0] busAddr,
  input logic       busAck,
  input logic       sclk,
  input logic       mosi,
  input logic [1:0] csN,
  input logic       xferActive,
  input logic       rxPend
);
  p_quiet_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !xferActive |-> (!sclk && !mosi));

  p_mosi_on_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    (xferActive && $past(xferActive) && !$fell(sclk)) |-> $stable(mosi));

  p_cs_only_by_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busValid && busWrite && busAddr == 4'h8) |-> $stable(csN));

  p_ready_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(busValid && busAddr == 4'hC && !xferActive && !rxPend) |-> xferActive);

  p_rx_mosi_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxPend |-> !mosi);

  p_quick_ack_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busAddr != 4'hC) |-> busAck);
endmodule

bind spi_flash_master spi_flash_master_chk u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busAck(busAck), .sclk(sclk), .mosi(mosi), .csN(csN),
  .xferActive(xferActive), .rxPend(rxPend)
);

// File: tb/spi_flash_master_bench.sv
module spi_flash_master_bench;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = 4'h0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busAck;
  logic        sclk, mosi;
  logic        miso = 1'b0;
  logic [1:0]  csN;

  int checks = 0;
  int bad = 0;
  bit finished = 1'b0;

  // reference model state
  int  cyc = 0;
  int  startCyc = -100000;
  int  nBits = 8;
  bit  modelRx = 1'b0;
  bit  txSeq [0:31];
  bit  flashSeq [0:31];
  bit [1:0] csModel = 2'b11;
  int  riseCnt = 0;
  bit  prevSclk = 1'b0;

  spi_flash_master #(.CLK_DIV(DIV)) u_spi_flash_master (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busAck(busAck), .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison of pins against the model
  always @(negedge clk) begin
    int m;
    bit on, expSclk, expMosi;
    if (rstN) begin
      m = cyc - startCyc;
      on = (m >= 0) && (m < 2*DIV*nBits);
      expSclk = on && (((m / DIV) % 2) == 1);
      expMosi = on && !modelRx && txSeq[m / (2*DIV)];
      check(sclk == expSclk, "R5", "sclk", 32'(sclk), 32'(expSclk));
      check(mosi == expMosi, modelRx ? "R8" : "R6", "mosi", 32'(mosi), 32'(expMosi));
      check(csN == csModel, "R3", "csN", 32'(csN), 32'(csModel));
      if (sclk && !prevSclk) riseCnt++;
      prevSclk = sclk;
      miso = (on && modelRx) ? flashSeq[m / (2*DIV)] : 1'b0;
    end
  end

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    #1 check(busAck == 1'b1, "R11", "write ack", 32'(busAck), 32'd1);
    @(posedge clk); #1 busValid = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 check(busAck == 1'b1, "R11", "read ack", 32'(busAck), 32'd1);
    d = busRdata;
    @(posedge clk); #1 busValid = 1'b0;
  endtask

  task automatic sendData(input logic [31:0] d, input int lenBytes, input bit msb);
    @(negedge clk);
    for (int i = 0; i < lenBytes; i++) begin
      int slot = msb ? i : lenBytes - 1 - i;
      logic [7:0] by = d[31 - 8*slot -: 8];
      for (int b = 0; b < 8; b++) txSeq[8*i + b] = by[7 - b];
    end
    modelRx = 1'b0; nBits = 8*lenBytes; riseCnt = 0;
    startCyc = cyc + 1;
    busValid = 1'b1; busWrite = 1'b1; busAddr = 4'hC; busWdata = d;
    #1 check(busAck == 1'b1, "R11", "data write ack", 32'(busAck), 32'd1);
    @(posedge clk); #1 busValid = 1'b0;
  endtask

  task automatic waitIdle(input string req);
    while (cyc - startCyc <= 2*DIV*nBits) @(negedge clk);
    @(negedge clk);
    check(riseCnt == nBits, req, "rising edges", 32'(riseCnt), 32'(nBits));
  endtask

  task automatic recvData(input logic [7:0] fb [4], input int lenBytes, input bit msb,
                          input string req);
    logic [31:0] expWord;
    int guard;
    @(negedge clk);
    expWord = '0;
    for (int i = 0; i < lenBytes; i++) begin
      int slot = msb ? i : lenBytes - 1 - i;
      expWord[31 - 8*slot -: 8] = fb[i];
      for (int b = 0; b < 8; b++) flashSeq[8*i + b] = fb[i][7 - b];
    end
    modelRx = 1'b1; nBits = 8*lenBytes; riseCnt = 0;
    startCyc = cyc + 1;
    busValid = 1'b1; busWrite = 1'b0; busAddr = 4'hC;
    guard = 0;
    #1;
    while (!busAck && guard < 2000) begin
      @(negedge clk); #1; guard++;
    end
    check(cyc - startCyc == 2*DIV*nBits, "R8", "ack cycle",
          32'(cyc - startCyc), 32'(2*DIV*nBits));
    check(busRdata == expWord, req, "rx word", busRdata, expWord);
    check(riseCnt == nBits, "R4", "rx rising edges", 32'(riseCnt), 32'(nBits));
    @(posedge clk); #1 busValid = 1'b0;
    modelRx = 1'b0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      bad++; checks++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [7:0] fb [4];
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset values
    regRead(4'h8, rd);
    check(rd == 32'hC800_0000, "R1", "status reset", rd, 32'hC800_0000);
    regRead(4'h0, rd);
    check(rd == 32'h0, "R1", "config reset", rd, 32'h0);

    // R2 masked storage
    regWrite(4'h0, 32'hFFFF_FFFF);
    regRead(4'h0, rd);
    check(rd == 32'h1800_0000, "R2", "config mask", rd, 32'h1800_0000);
    regWrite(4'h8, 32'hF7FF_FFFF);
    regRead(4'h8, rd);
    check(rd == 32'hF800_0000, "R2", "status mask", rd, 32'hF800_0000);

    // R3 select device 0
    regWrite(4'h0, 32'h0);
    regWrite(4'h8, 32'h4000_0000);
    csModel = 2'b10;
    regRead(4'h8, rd);
    check(rd == 32'h4800_0000, "R3", "status readback", rd, 32'h4800_0000);

    // R6 single byte from top lane
    sendData(32'hA53C_0F11, 1, 1'b0);
    waitIdle("R4");

    // R7 four bytes, msb-first, with busy probing (R10)
    regWrite(4'h0, 32'h0800_0000);
    regWrite(4'h8, 32'h7000_0000);
    sendData(32'h1234_5678, 4, 1'b1);
    regRead(4'h8, rd);
    check(rd[27] == 1'b0, "R10", "ready while busy", 32'(rd[27]), 32'd0);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 4'hC; busWdata = 32'hFFFF_FFFF;
    #1 check(busAck == 1'b1, "R10", "ignored write ack", 32'(busAck), 32'd1);
    @(posedge clk); #1 busValid = 1'b0;
    waitIdle("R7");
    regRead(4'h8, rd);
    check(rd[27] == 1'b1, "R10", "ready after", 32'(rd[27]), 32'd1);

    // R7 four bytes, lsb-first
    regWrite(4'h0, 32'h0);
    sendData(32'h1234_5678, 4, 1'b0);
    waitIdle("R7");

    // R6 three bytes both orders
    regWrite(4'h8, 32'h6000_0000);
    sendData(32'hABCD_EF99, 3, 1'b0);
    waitIdle("R6");
    regWrite(4'h0, 32'h0800_0000);
    sendData(32'hABCD_EF99, 3, 1'b1);
    waitIdle("R6");

    // R8 / R9 receives
    fb[0] = 8'h3C; fb[1] = 8'hC3; fb[2] = 8'h5A; fb[3] = 8'h96;
    regWrite(4'h0, 32'h1000_0000);
    regWrite(4'h8, 32'h7000_0000);
    recvData(fb, 4, 1'b1, "R9");
    regWrite(4'h0, 32'h0);
    recvData(fb, 4, 1'b0, "R9");
    regWrite(4'h8, 32'h4000_0000);
    recvData(fb, 1, 1'b0, "R8");
    regWrite(4'h8, 32'h5000_0000);
    recvData(fb, 2, 1'b0, "R8");
    regWrite(4'h0, 32'h1000_0000);
    recvData(fb, 2, 1'b1, "R9");

    // R3 deselect both
    regWrite(4'h8, 32'hC000_0000);
    csModel = 2'b11;
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule